// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight device request lines and presents one interrupt to a processor. A rising edge on a request line sets a bit in a pending register. The most urgent unmasked pending request is offered to the processor when the processor allows interrupts and nothing of equal or higher urgency is being serviced. Input 0 is the most urgent and input 7 the least. When the processor acknowledges, the block returns the vector number, which is the programmed base plus the input index, in the same cycle. The request then moves from the pending register to the in-service register.

A request of higher urgency than the one being serviced is offered at once, so handlers nest. A request of lower urgency waits. Software controls the block through a small write port with three targets: the vector base, the mask and a non-specific end-of-interrupt command. The mask can always be read back. Writing the vector base reinitialises the controller, and every request latched up to that moment is lost. A driver that rewrites the base while devices are active can therefore leave those devices waiting for service that never comes.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `int_req` is 0, `vec_out` is 0 and the mask read back on `reg_rdata` is 0x00.
- R2: A 0-to-1 transition on `irq_in[i]` sets pending bit i at the next clock edge. A line held high latches only once and is not latched again after its acknowledge.
- R3: Mask bit i = 1 masks input i. A masked input still latches into the pending register but is not offered. Once its mask bit is cleared it is offered.
- R4: `int_req` is 1 only under three conditions: `cpu_ie` is 1, an unmasked pending request exists, and the most urgent such request (lowest index) is strictly more urgent than every in-service bit.
- R5: With `int_ack` = 1 while `int_req` = 1, `vec_out` carries the vector in that same cycle. At the next edge the granted pending bit is cleared and its in-service bit is set. `int_ack` while `int_req` = 0 has no effect.
- R6: While a request is in service, a new request of equal or lower urgency stays pending. A more urgent one raises `int_req` at once, nesting over the current one.
- R7: A write to address 2 (end-of-interrupt) clears only the most urgent set in-service bit. Its data value is ignored.
- R8: After an end-of-interrupt, `int_req` is raised again if an unmasked pending request is more urgent than the remaining in-service bits. Otherwise the block waits, or goes idle if both registers are empty.
- R9: A write to address 1 loads the mask. `reg_rdata` shows the new mask from the next cycle on.
- R10: A write to address 0 loads the vector base and clears the pending register, the in-service register and the mask. Requests latched earlier, and any edge seen in that cycle, are lost.
- R11: A write to address 3 has no effect on the mask, the pending register or the in-service register.
- R12: `vec_out` is the 8-bit sum of base and input index while `int_req` = 1, and 0 while `int_req` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_ie | input | 1 | Processor interrupt enable |
| irq_in | input | 8 | Device request lines, rising-edge sensitive |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 2 | 0 vector base, 1 mask, 2 end-of-interrupt, 3 unused |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Current mask |
| int_ack | input | 1 | Processor acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the offered request |

## Verification
Directed sequences build specific nesting situations:
- a request lower in urgency than one in service, which must wait;
- a higher one, which must preempt;
- two end-of-interrupt commands, which must peel in-service bits off from the most urgent end;
- a masked line that latches while hidden.

The sequence that rewrites the base with a request latched shows that the request is lost, unlike a mask rewrite, which keeps it. Random traffic then mixes toggling lines, acknowledges, mask changes, end-of-interrupt commands and rare base rewrites. A cycle-level reference separates errors in the urgency comparison from errors in the edge latch and the bookkeeping of the two registers.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

  typedef enum logic [1:0] {
    ADDR_BASE  = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_EOI   = 2'd2,
    ADDR_SPARE = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Finds the lowest set index (most urgent) of a vector.
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign seen[g+1]  = seen[g] | vec[g];
      assign onehot[g]  = vec[g] & ~seen[g];
    end
  endgenerate

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_req_latch.sv
// Rising-edge detection and pending register.
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         clear_all,
  input  logic [N-1:0] grant_oh,
  output logic [N-1:0] pend_q
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] pend_d;

  always_comb begin
    rise = irq_in & ~prev_q;
    if (clear_all) pend_d = '0;
    else           pend_d = (pend_q & ~grant_oh) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/irq_service_reg.sv
// In-service register with non-specific end-of-interrupt.
module irq_service_reg #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_all,
  input  logic          eoi,
  input  logic [N-1:0]  grant_oh,
  output logic [N-1:0]  isr_q,
  output logic          top_found,
  output logic [IW-1:0] top_idx
);

  logic [N-1:0] top_oh;
  logic [N-1:0] isr_d;

  irq_prio_pick #(.N(N), .IW(IW)) top_pick_i (
    .vec    (isr_q),
    .found  (top_found),
    .idx    (top_idx),
    .onehot (top_oh)
  );

  always_comb begin
    if (clear_all)  isr_d = '0;
    else if (eoi)   isr_d = (isr_q & ~top_oh) | grant_oh;
    else            isr_d = isr_q | grant_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ie,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [VEC_W-1:0] reg_wdata,
  output logic [VEC_W-1:0] reg_rdata,
  input  logic             int_ack,
  output logic             int_req,
  output logic [VEC_W-1:0] vec_out
);
  import nest_irq_pkg::*;

  localparam int IW = $clog2(N_IRQ);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // register port decode
  logic base_wr;
  logic mask_wr;
  logic eoi_wr;

  always_comb begin
    base_wr = reg_we && (reg_addr == ADDR_BASE);
    mask_wr = reg_we && (reg_addr == ADDR_MASK);
    eoi_wr  = reg_we && (reg_addr == ADDR_EOI);
  end

  // base and mask registers with explicit enables
  logic [VEC_W-1:0] base_q, base_d;
  logic [N_IRQ-1:0] mask_q, mask_d;
  logic             base_en, mask_en;

  always_comb begin
    base_en = base_wr;
    base_d  = reg_wdata;
    mask_en = base_wr | mask_wr;
    mask_d  = base_wr ? '0 : reg_wdata[N_IRQ-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  // pending and in-service
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] isr_q;
  logic [N_IRQ-1:0] grant_oh;
  logic             isr_found;
  logic [IW-1:0]    isr_idx;

  irq_req_latch #(.N(N_IRQ)) req_latch_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .irq_in    (irq_in),
    .clear_all (base_wr),
    .grant_oh  (grant_oh),
    .pend_q    (pend_q)
  );

  irq_service_reg #(.N(N_IRQ), .IW(IW)) service_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_all (base_wr),
    .eoi       (eoi_wr),
    .grant_oh  (grant_oh),
    .isr_q     (isr_q),
    .top_found (isr_found),
    .top_idx   (isr_idx)
  );

  // candidate selection
  logic [N_IRQ-1:0] cand_vec;
  logic             cand_found;
  logic [IW-1:0]    cand_idx;
  logic [N_IRQ-1:0] cand_oh;

  assign cand_vec = pend_q & ~mask_q;

  irq_prio_pick #(.N(N_IRQ), .IW(IW)) cand_pick_i (
    .vec    (cand_vec),
    .found  (cand_found),
    .idx    (cand_idx),
    .onehot (cand_oh)
  );

  logic req_c;

  always_comb begin
    req_c = cpu_ie && cand_found && (!isr_found || (cand_idx < isr_idx));
    if (int_ack && req_c && !base_wr) grant_oh = cand_oh;
    else                              grant_oh = '0;
  end

  assign int_req   = req_c;
  assign vec_out   = req_c ? (base_q + VEC_W'(cand_idx)) : '0;
  assign reg_rdata = VEC_W'(mask_q);

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int N = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ie,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [VW-1:0] reg_wdata,
  input logic [VW-1:0] reg_rdata,
  input logic          int_ack,
  input logic          int_req,
  input logic [VW-1:0] vec_out,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  isr_q
);

  p_no_ie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ie |-> !int_req);

  p_vec_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> (vec_out == '0));

  p_ack_sets_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req && !(reg_we && reg_addr == 2'd0)) |=> (isr_q != '0));

  p_isr_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ack && int_req) |=> ($countones(isr_q) <= $past($countones(isr_q))));

  p_eoi_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && isr_q != '0 && !(int_ack && int_req))
      |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

  p_mask_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> (reg_rdata == $past(reg_wdata)));

  p_reinit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0)
      |=> (pend_q == '0 && isr_q == '0 && reg_rdata == '0));

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N(N_IRQ), .VW(VEC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_ie    (cpu_ie),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .int_ack   (int_ack),
  .int_req   (int_req),
  .vec_out   (vec_out),
  .pend_q    (pend_q),
  .isr_q     (isr_q)
);

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;

  logic       clk;
  logic       rst_n;
  logic       cpu_ie;
  logic [7:0] irq_in;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       int_ack;
  logic       int_req;
  logic [7:0] vec_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_pend, m_isr, m_mask, m_base, m_prev;

  nest_irq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ie    (cpu_ie),
    .irq_in    (irq_in),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .int_ack   (int_ack),
    .int_req   (int_req),
    .vec_out   (vec_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_req();
    int c, t;
    c = first_set(m_pend & ~m_mask);
    t = first_set(m_isr);
    return cpu_ie && (c < 8) && (c < t);
  endfunction

  function automatic logic [7:0] exp_vec();
    if (!exp_req()) return 8'h00;
    return m_base + 8'(first_set(m_pend & ~m_mask));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: check outputs, advance reference, return at falling edge
  task automatic tick();
    logic [7:0] grant, eclr, rise;
    logic       basew;
    int         c, t;
    #1;
    chk("R4 int_req", {7'd0, int_req}, {7'd0, exp_req()});
    chk(exp_req() ? "R5 vec_out" : "R12 vec_out", vec_out, exp_vec());
    chk("R9 reg_rdata", reg_rdata, m_mask);
    c     = first_set(m_pend & ~m_mask);
    t     = first_set(m_isr);
    basew = reg_we && (reg_addr == 2'd0);
    rise  = irq_in & ~m_prev;
    grant = (int_ack && exp_req() && !basew) ? (8'h01 << c) : 8'h00;
    eclr  = (reg_we && reg_addr == 2'd2 && t < 8) ? (8'h01 << t) : 8'h00;
    @(posedge clk);
    m_prev = irq_in;
    if (basew) begin
      m_pend = 8'h00; m_isr = 8'h00; m_mask = 8'h00; m_base = reg_wdata;
    end else begin
      m_pend = (m_pend & ~grant) | rise;
      m_isr  = (m_isr & ~eclr) | grant;
      if (reg_we && reg_addr == 2'd1) m_mask = reg_wdata;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic ack_cycle();
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
  endtask

  task automatic set_irq(logic [7:0] v);
    irq_in = v;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0005EED5));
    rst_n = 1'b0; cpu_ie = 1'b0; irq_in = 8'h00; reg_we = 1'b0;
    reg_addr = 2'd0; reg_wdata = 8'h00; int_ack = 1'b0;
    m_pend = 0; m_isr = 0; m_mask = 0; m_base = 0; m_prev = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 int_req", {7'd0, int_req}, 8'h00);
    chk("R1 vec_out", vec_out, 8'h00);
    chk("R1 mask", reg_rdata, 8'h00);

    // nesting
    cpu_ie = 1'b1;
    wr(2'd0, 8'h08);
    set_irq(8'h08);
    #1 chk("R2 edge latched req", {7'd0, int_req}, 8'h01);
    chk("R2 vector", vec_out, 8'h0B);
    ack_cycle();
    #1 chk("R2 held line not relatched", {7'd0, int_req}, 8'h00);
    set_irq(8'h28);
    #1 chk("R6 lower waits", {7'd0, int_req}, 8'h00);
    set_irq(8'h2A);
    #1 chk("R6 higher nests", {7'd0, int_req}, 8'h01);
    chk("R6 nest vector", vec_out, 8'h09);
    ack_cycle();
    wr(2'd2, 8'hFF);
    #1 chk("R7 only top cleared", {7'd0, int_req}, 8'h00);
    wr(2'd2, 8'h00);
    #1 chk("R8 re-raise", {7'd0, int_req}, 8'h01);
    chk("R8 vector", vec_out, 8'h0D);
    ack_cycle();
    wr(2'd2, 8'h00);
    set_irq(8'h00);
    #1 chk("R8 idle", {7'd0, int_req}, 8'h00);

    // masking
    wr(2'd1, 8'h04);
    #1 chk("R9 readback", reg_rdata, 8'h04);
    set_irq(8'h04);
    set_irq(8'h00);
    #1 chk("R3 masked hidden", {7'd0, int_req}, 8'h00);
    wr(2'd1, 8'h00);
    #1 chk("R3 unmasked offered", {7'd0, int_req}, 8'h01);
    chk("R3 vector", vec_out, 8'h0A);
    ack_cycle();
    wr(2'd2, 8'h00);

    // unused address is not an end-of-interrupt
    set_irq(8'h01);
    set_irq(8'h00);
    ack_cycle();
    set_irq(8'h02);
    set_irq(8'h00);
    wr(2'd3, 8'hFF);
    #1 chk("R11 no eoi", {7'd0, int_req}, 8'h00);
    chk("R11 mask kept", reg_rdata, 8'h00);
    wr(2'd2, 8'h00);
    #1 chk("R7 eoi frees lower", vec_out, 8'h09);
    ack_cycle();
    wr(2'd2, 8'h00);

    // reinitialisation loses latched requests
    cpu_ie = 1'b0;
    set_irq(8'h40);
    set_irq(8'h00);
    #1 chk("R4 ie low blocks", {7'd0, int_req}, 8'h00);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h70);
    cpu_ie = 1'b1;
    tick();
    #1 chk("R10 request lost", {7'd0, int_req}, 8'h00);
    chk("R10 mask cleared", reg_rdata, 8'h00);
    chk("R12 vec zero", vec_out, 8'h00);
    set_irq(8'h01);
    #1 chk("R10 new base", vec_out, 8'h70);
    ack_cycle();
    ack_cycle();
    #1 chk("R5 stray ack", {7'd0, int_req}, 8'h00);
    wr(2'd2, 8'h00);
    set_irq(8'h00);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      cpu_ie  = ($urandom % 8) != 0;
      irq_in  = irq_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      int_ack = ($urandom % 3) == 0;
      reg_we  = ($urandom % 5) == 0;
      r = $urandom % 40;
      reg_addr  = (r == 0) ? 2'd0 : (r < 12) ? 2'd1 : (r < 36) ? 2'd2 : 2'd3;
      reg_wdata = 8'($urandom) & 8'($urandom);
      tick();
    end
    reg_we = 1'b0; int_ack = 1'b0;
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule